// File: doc/BRIEF.md
# Manchester Subcarrier Frame Decoder

This block turns the output of a subcarrier detector into frame content for the card-to-reader direction of a 106 kbit/s proximity link. The detector output is oversampled eight times per bit period. Each bit period is split into two halves of four samples. One byte of samples, earliest sample in the MSB, arrives on every cycle that `samp_valid` is high.

While idle, the decoder hunts for the start-of-frame symbol at one of three sample alignments. Once it locks, it classifies each half-bit as modulated or not. From that it decodes one bit per sample byte and packs the bits into 9-bit characters, LSB first. The low eight bits of each character are emitted as a data byte, and the ninth bit is appended to a parity shift register. A bit-count preload lets anticollision frames, which begin part-way through a character, place their parity bits correctly.

A half-bit period with no modulation ends the frame. Leftover bits are flushed as a final right-justified byte, and a completion pulse is raised. A frame that carried nothing is dropped silently, and the hunt resumes. Start and end timestamps are given in sample units, counted from reset.

Top module: `mcd_frame_decoder`

## Requirements
- R1: A 4-sample half-bit nibble counts as modulated exactly when at least three of its four bits are 1. The modulated values are 0x7, 0xB, 0xD, 0xE and 0xF.
- R2: While hunting, with window W = {last two samples of the previous byte, current byte} (current byte in bits 7..0), offset s in {2, 1, 0} is found when (W & (0x0EE << s)) == (0x0E0 << s). Offset 2 is tried first, then 1, then 0. The first match wins, and the following bit periods are taken from W bits 7+s..s.
- R3: On lock, `start_time` becomes the sample counter (8 × bytes accepted before the locking byte) with its low three bits cleared, minus the offset.
- R4: After lock, each sample byte decodes one bit. Modulation in the first half only (bits 7..4) gives 1, and modulation in the second half only gives 0. Bits fill a 9-bit character LSB first. When nine bits are complete, bits 7..0 are output with a one-cycle `byte_valid` strobe, `byte_count` increments, and bit 8 is shifted into the LSB of `parity_bits`.
- R5: On lock, the bit counter is preloaded from `bit_offset` (0..8), so the first character is completed after 9 − `bit_offset` bits.
- R6: After every decoded bit, `end_time` = `start_time` + 8 × (9 × `byte_count` + bit counter + 1). On lock, `end_time` equals `start_time`.
- R7: A bit period with no modulation in either half ends a frame that holds bytes or bits. Any k pending bits (k > 0) are emitted right-justified as one byte, with a 0 shifted into `parity_bits`. `frame_done` pulses for one cycle in the same cycle, and the decoder returns to hunting.
- R8: If the frame ends with no bytes and a zero bit counter, no byte and no `frame_done` are produced, and hunting resumes so that a later frame decodes normally.
- R9: A bit period modulated in both halves aborts the frame with no `frame_done` and no further bytes, and the decoder returns to hunting.
- R10: After reset, all outputs are zero and the decoder is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_valid | input | 1 | Qualifies `samp_byte` |
| samp_byte | input | 8 | Eight detector samples, earliest in bit 7 |
| bit_offset | input | 4 | Bit-counter preload applied at lock (0..8) |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Decoded data byte |
| parity_bits | output | PAR_W | Parity shift register, newest bit in LSB |
| byte_count | output | CNT_W | Bytes emitted in the current frame |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| start_time | output | TW | Frame start in samples |
| end_time | output | TW | Running frame end in samples |

## Verification
The assertions assume three things about the inputs. `samp_byte` matters only when `samp_valid` is high. `bit_offset` stays stable and within 0..8 for the whole of a frame. Each valid byte carries exactly one bit period of samples. The stimulus drives only whole sample bytes and sets `bit_offset` before the leading idle samples of each frame. It also builds every frame with idle samples in front, so that the decoder locks at the intended offset and only there.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int SAMP_PER_BIT = 8;
  localparam int SAMP_PER_HALF = SAMP_PER_BIT / 2;
  typedef enum logic {ST_HUNT = 1'b0, ST_DEC = 1'b1} mcd_state_e;
endpackage

// File: rtl/mcd_rst_sync.sv
module mcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/mcd_nib_class.sv
module mcd_nib_class (
  input  logic [3:0] nib,
  output logic       mod
);
  always_comb begin
    unique case (nib)
      4'h7, 4'hB, 4'hD, 4'hE, 4'hF: mod = 1'b1;
      default:                      mod = 1'b0;
    endcase
  end

  // R1: three or more ones mark a modulated half-bit
  always_comb begin
    if (!$isunknown(nib)) begin
      a_r1_nibble_rule: assert (mod == ($countones(nib) >= 3));
    end
  end
endmodule

// File: rtl/mcd_sync_find.sv
module mcd_sync_find #(
  parameter int NOFF  = 3,
  parameter int WIN_W = 10,
  parameter int OFF_W = 2
) (
  input  logic [WIN_W-1:0] win,
  output logic [OFF_W-1:0] off
);
  localparam logic [WIN_W-1:0] BASE_MASK = WIN_W'(10'h0EE);
  localparam logic [WIN_W-1:0] BASE_PAT  = WIN_W'(10'h0E0);
  localparam logic [OFF_W-1:0] OFF_NONE  = '1;

  logic [NOFF-1:0] hit;

  for (genvar s = 0; s < NOFF; s++) begin : g_off
    assign hit[s] = ((win & (BASE_MASK << s)) == (BASE_PAT << s));
  end

  // highest offset has priority
  always_comb begin
    off = OFF_NONE;
    for (int s = 0; s < NOFF; s++) begin
      if (hit[s]) off = OFF_W'(s);
    end
  end
endmodule

// File: rtl/mcd_frame_decoder.sv
module mcd_frame_decoder
  import mcd_pkg::*;
#(
  parameter int TW    = 32,
  parameter int PAR_W = 16,
  parameter int CNT_W = 8,
  parameter int NOFF  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_valid,
  input  logic [7:0]       samp_byte,
  input  logic [3:0]       bit_offset,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [PAR_W-1:0] parity_bits,
  output logic [CNT_W-1:0] byte_count,
  output logic             frame_done,
  output logic [TW-1:0]    start_time,
  output logic [TW-1:0]    end_time
);
  localparam int HIST_W = NOFF - 1;
  localparam int WIN_W  = SAMP_PER_BIT + HIST_W;
  localparam int OFF_W  = $clog2(NOFF + 1);
  localparam logic [OFF_W-1:0] OFF_NONE = '1;
  localparam logic [3:0] CHAR_BITS = 4'd9;

  logic rst_sn;
  mcd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  mcd_state_e       state_q, state_d;
  logic [HIST_W-1:0] prev_q, prev_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [8:0]       sr_q, sr_d;
  logic [3:0]       bc_q, bc_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [PAR_W-1:0] par_q, par_d;
  logic [TW-1:0]    cnt_q, cnt_d;
  logic [TW-1:0]    start_q, start_d;
  logic [TW-1:0]    end_q, end_d;
  logic             bv_q, bv_d;
  logic [7:0]       byte_q, byte_d;
  logic             done_q, done_d;

  logic [WIN_W-1:0] win;
  logic [OFF_W-1:0] sync_off;
  logic [7:0]       period;
  logic [1:0]       half_mod;

  assign win    = {prev_q, samp_byte};
  assign period = 8'(win >> off_q);

  mcd_sync_find #(.NOFF(NOFF), .WIN_W(WIN_W), .OFF_W(OFF_W)) u_find (
    .win(win),
    .off(sync_off)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    mcd_nib_class u_nib (
      .nib(period[SAMP_PER_HALF*h +: SAMP_PER_HALF]),
      .mod(half_mod[h])
    );
  end

  logic       bit_val;
  logic [8:0] sr_n;
  logic [3:0] bc_n;
  logic [TW-1:0] units;

  always_comb begin
    state_d = state_q;
    prev_d  = prev_q;
    off_d   = off_q;
    sr_d    = sr_q;
    bc_d    = bc_q;
    len_d   = len_q;
    par_d   = par_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    end_d   = end_q;
    byte_d  = byte_q;
    bv_d    = 1'b0;
    done_d  = 1'b0;
    bit_val = half_mod[1];
    sr_n    = {bit_val, sr_q[8:1]};
    bc_n    = bc_q + 4'd1;
    units   = '0;

    if (samp_valid) begin
      cnt_d  = cnt_q + TW'(SAMP_PER_BIT);
      prev_d = samp_byte[HIST_W-1:0];
      if (state_q == ST_HUNT) begin
        if (sync_off != OFF_NONE) begin
          state_d = ST_DEC;
          off_d   = sync_off;
          start_d = {cnt_q[TW-1:3], 3'b000} - TW'(sync_off);
          end_d   = start_d;
          bc_d    = bit_offset;
          len_d   = '0;
          par_d   = '0;
          sr_d    = '0;
        end
      end else begin
        unique case (half_mod)
          2'b11: begin
            state_d = ST_HUNT;
            prev_d  = '0;
          end
          2'b10, 2'b01: begin
            sr_d = sr_n;
            if (bc_n == CHAR_BITS) begin
              byte_d = sr_n[7:0];
              bv_d   = 1'b1;
              par_d  = {par_q[PAR_W-2:0], sr_n[8]};
              len_d  = len_q + CNT_W'(1);
              bc_d   = '0;
            end else begin
              bc_d = bc_n;
            end
            units = (TW'(len_d) << 3) + TW'(len_d) + TW'(bc_d) + TW'(1);
            end_d = start_q + (units << 3);
          end
          default: begin
            state_d = ST_HUNT;
            prev_d  = '0;
            if (len_q != '0 || bc_q != '0) begin
              done_d = 1'b1;
              if (bc_q != '0) begin
                byte_d = 8'(sr_q >> (CHAR_BITS - bc_q));
                bv_d   = 1'b1;
                par_d  = {par_q[PAR_W-2:0], 1'b0};
                len_d  = len_q + CNT_W'(1);
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_HUNT;
      prev_q  <= '0;
      off_q   <= '0;
      sr_q    <= '0;
      bc_q    <= '0;
      len_q   <= '0;
      par_q   <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      byte_q  <= '0;
      bv_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      bv_q   <= bv_d;
      done_q <= done_d;
      if (samp_valid) begin
        state_q <= state_d;
        prev_q  <= prev_d;
        off_q   <= off_d;
        sr_q    <= sr_d;
        bc_q    <= bc_d;
        len_q   <= len_d;
        par_q   <= par_d;
        cnt_q   <= cnt_d;
        start_q <= start_d;
        end_q   <= end_d;
        byte_q  <= byte_d;
      end
    end
  end

  assign byte_valid  = bv_q;
  assign byte_data   = byte_q;
  assign parity_bits = par_q;
  assign byte_count  = len_q;
  assign frame_done  = done_q;
  assign start_time  = start_q;
  assign end_time    = end_q;

  // R4: a byte strobe only follows an accepted sample byte
  a_r4_byte_needs_sample: assert property (@(posedge clk) disable iff (!rst_sn)
    bv_q |-> $past(samp_valid));

  // R4: each strobe advances the byte count by one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_sn)
    bv_q |-> len_q == $past(len_q) + CNT_W'(1));

  // R8: completion is never signalled for an empty frame
  a_r8_done_nonempty: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> len_q != '0);

  // R7: after completion the decoder is hunting again
  a_r7_done_returns_hunt: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> state_q == ST_HUNT);
endmodule

// File: tb/mcd_frame_decoder_tb.sv
module mcd_frame_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [7:0]  samp_byte = 8'h00;
  logic [3:0]  bit_offset = 4'd0;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic [15:0] parity_bits;
  logic [7:0]  byte_count;
  logic        frame_done;
  logic [31:0] start_time;
  logic [31:0] end_time;

  mcd_frame_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_byte(samp_byte),
    .bit_offset(bit_offset), .byte_valid(byte_valid), .byte_data(byte_data),
    .parity_bits(parity_bits), .byte_count(byte_count), .frame_done(frame_done),
    .start_time(start_time), .end_time(end_time)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // monitor of registered outputs, sampled on the falling edge
  logic [7:0]  got_bytes [0:63];
  int          got_n;
  int          done_n;
  logic [31:0] done_start, done_end;
  logic [15:0] done_par;

  always @(negedge clk) begin
    if (byte_valid && got_n < 64) begin
      got_bytes[got_n] = byte_data;
      got_n = got_n + 1;
    end
    if (frame_done) begin
      done_n = done_n + 1;
      done_start = start_time;
      done_end = end_time;
      done_par = parity_bits;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // sample stream builder
  logic sbits [0:1023];
  int   slen;
  int   bytes_sent = 0;
  logic exp_bits [0:63];
  int   nbits;
  logic [7:0]  exp_bytes [0:63];
  int          exp_n;
  logic [15:0] exp_par;
  bit          exp_done;

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sbits[slen] = v[i];
      slen = slen + 1;
    end
  endtask

  task automatic put_zeros(input int n);
    for (int i = 0; i < n; i++) begin
      sbits[slen] = 1'b0;
      slen = slen + 1;
    end
  endtask

  task automatic begin_frame(input int s);
    slen = 0;
    put_zeros(16 - s);
    put_byte(8'hF0);
  endtask

  task automatic put_data_bits();
    for (int i = 0; i < nbits; i++) put_byte(exp_bits[i] ? 8'hF0 : 8'h0F);
  endtask

  task automatic send_stream();
    put_zeros(24 + ((8 - (slen % 8)) % 8));
    got_n = 0;
    done_n = 0;
    for (int k = 0; k < slen / 8; k++) begin
      @(negedge clk);
      samp_valid = 1'b1;
      for (int j = 0; j < 8; j++) samp_byte[7-j] = sbits[8*k + j];
      bytes_sent = bytes_sent + 1;
    end
    @(negedge clk);
    samp_valid = 1'b0;
    samp_byte = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic model(input int o);
    logic [8:0] sr;
    int c;
    sr = '0;
    c = o;
    exp_n = 0;
    exp_par = '0;
    for (int i = 0; i < nbits; i++) begin
      sr = {exp_bits[i], sr[8:1]};
      c = c + 1;
      if (c == 9) begin
        exp_bytes[exp_n] = sr[7:0];
        exp_n = exp_n + 1;
        exp_par = {exp_par[14:0], sr[8]};
        c = 0;
      end
    end
    exp_done = (exp_n > 0) || (c > 0);
    if (c > 0) begin
      exp_bytes[exp_n] = 8'(sr >> (9 - c));
      exp_n = exp_n + 1;
      exp_par = {exp_par[14:0], 1'b0};
    end
  endtask

  task automatic set_bits(input logic [63:0] v, input int n);
    nbits = n;
    for (int i = 0; i < n; i++) exp_bits[i] = v[i];
  endtask

  // full frame: sync at offset s, preload o, data bits, idle end
  task automatic run_frame(input int s, input int o, input string req);
    int base;
    logic [31:0] exp_start;
    bit_offset = 4'(o);
    base = bytes_sent;
    begin_frame(s);
    put_data_bits();
    put_zeros(8);
    model(o);
    send_stream();
    exp_start = 32'(8 * (base + 2) - s);
    check(done_n == 1, {req, " R7 done pulse count"}, done_n, 1);
    check(got_n == exp_n, {req, " R4 byte count"}, got_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      check(got_bytes[i] == exp_bytes[i], {req, " R4 data byte"}, got_bytes[i], exp_bytes[i]);
    check(done_par == exp_par, {req, " R4 parity bits"}, done_par, exp_par);
    check(done_start == exp_start, {req, " R3 start time"}, done_start, exp_start);
    check(done_end == exp_start + 32'(8 * (o + nbits + 1)), {req, " R6 end time"},
          done_end, exp_start + 32'(8 * (o + nbits + 1)));
  endtask

  task automatic t_reset();
    check(byte_valid == 1'b0 && frame_done == 1'b0, "R10 strobes low", {byte_valid, frame_done}, 0);
    check(byte_count == 8'd0 && parity_bits == 16'd0, "R10 count/parity zero",
          {byte_count, parity_bits}, 0);
    check(start_time == 32'd0 && end_time == 32'd0, "R10 times zero", start_time | end_time, 0);
  endtask

  task automatic t_empty();
    bit_offset = 4'd0;
    begin_frame(0);
    put_zeros(8);
    send_stream();
    check(done_n == 0, "R8 empty frame no done", done_n, 0);
    check(got_n == 0, "R8 empty frame no byte", got_n, 0);
    set_bits(64'h0000_0000_0000_0135, 9);
    run_frame(0, 0, "R8 recovery");
  endtask

  task automatic t_error();
    bit_offset = 4'd0;
    begin_frame(0);
    put_byte(8'hF0);
    put_byte(8'h0F);
    put_byte(8'hFF);
    put_byte(8'hF0);
    put_zeros(8);
    send_stream();
    check(done_n == 0, "R9 coding error no done", done_n, 0);
    check(got_n == 0, "R9 coding error no byte", got_n, 0);
  endtask

  task automatic t_nibbles();
    int base;
    logic [31:0] exp_start;
    bit_offset = 4'd0;
    base = bytes_sent;
    begin_frame(0);
    put_byte(8'hE0);
    put_byte(8'h3D);
    put_byte(8'hB6);
    put_byte(8'h57);
    put_byte(8'h66);
    send_stream();
    exp_start = 32'(8 * (base + 2));
    check(done_n == 1, "R1 done after two-ones nibbles", done_n, 1);
    check(got_n == 1 && got_bytes[0] == 8'h05, "R1 decoded nibble variants", got_bytes[0], 8'h05);
    check(done_end == exp_start + 32'd40, "R6 end time partial", done_end, exp_start + 32'd40);
  endtask

  initial begin
    got_n = 0;
    done_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // R4: 0xA5 with parity 1 at offset 0
    set_bits(64'h0000_0000_0000_01A5, 9);
    run_frame(0, 0, "R4 single char");
    // R2 offset 1, two chars and a 4-bit tail (R7)
    set_bits({38'd0, 4'b1011, 1'b1, 8'h81, 1'b0, 8'h3C}, 22);
    run_frame(1, 0, "R2 offset1");
    // R2 priority of offset 2 over 1, R5 preload 3
    set_bits({54'd0, 10'b11_1010_1101}, 10);
    run_frame(2, 3, "R5 preload");
    t_empty();
    t_error();
    t_nibbles();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule